// File: doc/BRIEF.md
# Wave-Augmented DAC Channel Code Generator

This block produces the 12-bit conversion code for a single converter channel. Software places a base level in a holding register through a small write port. The block can then add one of two generated waveforms to that level. The first is pseudo-random noise from a 12-bit linear feedback shift register. The second is a symmetric triangle from a bounded up/down counter. A 2-bit mode input selects the waveform. A 4-bit amplitude code sets both the triangle peak and how many low bits of the noise word are kept.

Each single-cycle trigger pulse advances the active generator by one step and reloads the output register. The new value is the base plus the waveform value, clamped at full scale. In idle mode both generators are held at their starting state. A base write in idle mode goes straight to the output, so the block then acts as a plain holding register.

Top module: `dac_wave_synth`

## Requirements
- R1: While reset is asserted and on release, `code_out` is 0 and the base level is 0. The noise register starts at 0xAAA and the triangle counter starts at 0, counting upward.
- R2: With `wave_mode` = 00 both generators return to their starting state on every clock. A trigger in mode 00 does not advance either generator, so the first noise step after leaving mode 00 always starts from 0xAAA.
- R3: The base plus the waveform value is clamped to 0xFFF. The output never wraps.
- R4: With `wave_mode` = 01, each trigger advances the noise register r. The new value is {r[10:0], f}, where f = r[11]^r[5]^r[3]^r[0], inverted when r[10:0] is all zero. The output then becomes the saturated sum of the base and the masked new value.
- R5: Amplitude code n from 0 to 11 keeps noise bits [n:0] and clears the bits above. Codes 12 to 15 act as code 11 and keep all 12 bits.
- R6: In triangle mode, each trigger moves the counter one step. It climbs from 0 to the peak 2^(n+1)−1, where n is the amplitude code clamped to 11. It then descends to 0 and climbs again. The output is the saturated sum of the base and the new counter value.
- R7: Mode values 10 and 11 both select the triangle.
- R8: `code_out` changes only at a clock edge that samples `trig` high, or one that samples a base write in mode 00. Otherwise it holds its value.
- R9: A base write in mode 00 loads the written value into `code_out` at that edge. In modes 01, 10 and 11 a write only updates the base, and the output picks it up at the next trigger.
- R10: The noise sequence has period 4096. It passes through the all-zero word and leaves it on the next step, because a zero state steps to 0x001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the base level |
| base_wdata | input | 12 | Base level written when `base_we` is high |
| wave_mode | input | 2 | 00 idle, 01 noise, 1x triangle |
| amp_sel | input | 4 | Amplitude code for triangle peak and noise mask |
| trig | input | 1 | Single-cycle step strobe |
| code_out | output | 12 | Registered conversion code |

## Verification
The hardest state to reach is the noise register holding the all-zero word, together with the recovery step that follows it. It comes up only once in 4096 steps, and only if the register was started from its seed. To reach it, the bench clears the generators in idle mode, selects noise with a full mask and a zero base, and fires 4096 triggers. It compares every output against its own model of the shift register. It also confirms that a zero output appeared and that the output returned to the seed at the end of the period. The saturating corners are reached by pairing bases near full scale with the triangle peak and with known noise values.

// File: rtl/dws_pkg.sv
package dws_pkg;

  localparam int unsigned CODE_W = 12;
  localparam int unsigned AMP_W  = 4;
  localparam logic [CODE_W-1:0] NOISE_SEED = 12'hAAA;
  // feedback taps at register bits 11, 5, 3 and 0
  localparam logic [CODE_W-1:0] NOISE_TAPS = 12'h829;

  typedef enum logic [1:0] {
    WM_IDLE  = 2'b00,
    WM_NOISE = 2'b01,
    WM_TRI_A = 2'b10,
    WM_TRI_B = 2'b11
  } wave_mode_e;

  // low-bit mask selected by the amplitude code, clamped to the full width
  function automatic logic [CODE_W-1:0] amp_mask(input logic [AMP_W-1:0] sel);
    int unsigned n;
    n = (int'(sel) > int'(CODE_W) - 1) ? CODE_W - 1 : int'(sel);
    return {CODE_W{1'b1}} >> (CODE_W - 1 - n);
  endfunction

  // addition that clamps at full scale
  function automatic logic [CODE_W-1:0] sat_add(input logic [CODE_W-1:0] a,
                                                input logic [CODE_W-1:0] b);
    logic [CODE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CODE_W] ? {CODE_W{1'b1}} : s[CODE_W-1:0];
  endfunction

  // one shift of the noise register, zero-escape term included
  function automatic logic [CODE_W-1:0] noise_step_fn(input logic [CODE_W-1:0] r);
    logic fb;
    fb = (^(r & NOISE_TAPS)) ^ (~|r[CODE_W-2:0]);
    return {r[CODE_W-2:0], fb};
  endfunction

endpackage

// File: rtl/dws_noise.sv
module dws_noise
  import dws_pkg::*;
#(
  parameter int unsigned W    = CODE_W,
  parameter int unsigned AW   = AMP_W,
  parameter logic [W-1:0] SEED = NOISE_SEED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [AW-1:0] amp_sel,
  output logic [W-1:0]  lfsr_q,
  output logic [W-1:0]  noise_val
);

  logic [W-1:0] lfsr_nxt;

  always_comb begin
    lfsr_nxt  = noise_step_fn(lfsr_q);
    noise_val = lfsr_nxt & amp_mask(amp_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lfsr_q <= SEED;
    end else if (step) begin
      lfsr_q <= lfsr_nxt;
    end
  end

endmodule

// File: rtl/dws_tri.sv
module dws_tri
  import dws_pkg::*;
#(
  parameter int unsigned W  = CODE_W,
  parameter int unsigned AW = AMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [AW-1:0] amp_sel,
  output logic [W-1:0]  cnt_q,
  output logic [W-1:0]  cnt_nxt
);

  logic         rising_q;
  logic         rising_nxt;
  logic [W-1:0] peak;

  always_comb begin
    peak = amp_mask(amp_sel);
    if (rising_q) begin
      if (cnt_q >= peak) begin
        rising_nxt = 1'b0;
        cnt_nxt    = cnt_q - 1'b1;
      end else begin
        rising_nxt = 1'b1;
        cnt_nxt    = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        rising_nxt = 1'b1;
        cnt_nxt    = cnt_q + 1'b1;
      end else begin
        rising_nxt = 1'b0;
        cnt_nxt    = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q    <= '0;
      rising_q <= 1'b1;
    end else if (step) begin
      cnt_q    <= cnt_nxt;
      rising_q <= rising_nxt;
    end
  end

endmodule

// File: rtl/dws_outreg.sv
module dws_outreg
  import dws_pkg::*;
#(
  parameter int unsigned W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         base_we,
  input  logic [W-1:0] base_wdata,
  input  logic         idle,
  input  logic         load,
  input  logic [W-1:0] wave_val,
  output logic [W-1:0] base_q,
  output logic [W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      code_q <= '0;
    end else begin
      if (base_we) begin
        base_q <= base_wdata;
      end
      if (idle && base_we) begin
        code_q <= base_wdata;
      end else if (load) begin
        code_q <= sat_add(base_q, wave_val);
      end
    end
  end

endmodule

// File: rtl/dac_wave_synth.sv
module dac_wave_synth
  import dws_pkg::*;
#(
  parameter int unsigned DATA_W = CODE_W,
  parameter int unsigned SEL_W  = AMP_W,
  parameter logic [DATA_W-1:0] SEED = NOISE_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [DATA_W-1:0] base_wdata,
  input  logic [1:0]        wave_mode,
  input  logic [SEL_W-1:0]  amp_sel,
  input  logic              trig,
  output logic [DATA_W-1:0] code_out
);

  wave_mode_e mode;
  logic gen_clear;
  logic noise_step;
  logic tri_step;

  logic [DATA_W-1:0] lfsr_q;
  logic [DATA_W-1:0] noise_val;
  logic [DATA_W-1:0] tri_cnt;
  logic [DATA_W-1:0] tri_nxt;
  logic [DATA_W-1:0] wave_val;
  logic [DATA_W-1:0] base_val;

  always_comb begin
    mode       = wave_mode_e'(wave_mode);
    gen_clear  = (mode == WM_IDLE);
    noise_step = trig && (mode == WM_NOISE);
    tri_step   = trig && (mode == WM_TRI_A || mode == WM_TRI_B);
    unique case (mode)
      WM_NOISE:          wave_val = noise_val;
      WM_TRI_A, WM_TRI_B: wave_val = tri_nxt;
      default:           wave_val = '0;
    endcase
  end

  dws_noise #(.W(DATA_W), .AW(SEL_W), .SEED(SEED)) u_noise (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (gen_clear),
    .step      (noise_step),
    .amp_sel   (amp_sel),
    .lfsr_q    (lfsr_q),
    .noise_val (noise_val)
  );

  dws_tri #(.W(DATA_W), .AW(SEL_W)) u_tri (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (gen_clear),
    .step    (tri_step),
    .amp_sel (amp_sel),
    .cnt_q   (tri_cnt),
    .cnt_nxt (tri_nxt)
  );

  dws_outreg #(.W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_we    (base_we),
    .base_wdata (base_wdata),
    .idle       (gen_clear),
    .load       (trig),
    .wave_val   (wave_val),
    .base_q     (base_val),
    .code_q     (code_out)
  );

endmodule

// File: rtl/dws_chk.sv
module dws_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         trig,
  input logic [1:0]   wave_mode,
  input logic         base_we,
  input logic [W-1:0] base_wdata,
  input logic [W-1:0] code_out,
  input logic [W-1:0] base_val,
  input logic [W-1:0] lfsr_q,
  input logic [W-1:0] tri_cnt,
  input logic         tri_step,
  input logic         noise_step,
  input logic         gen_clear
);

  // R1: output comes out of reset at zero
  a_r1_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> (code_out == '0));

  // R2: idle mode parks both generators
  a_r2_idle_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == 2'b00) |=> (tri_cnt == '0 && lfsr_q == 12'hAAA));

  // R3: a trigger never yields less than the base it was summed with
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && wave_mode != 2'b00 && !base_we) |=> (code_out >= $past(base_val)));

  // R6: each triangle step moves the counter by exactly one
  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_step && !gen_clear) |=>
      ((tri_cnt == $past(tri_cnt) + 1'b1) || ($past(tri_cnt) == tri_cnt + 1'b1)));

  // R8: output holds without a trigger or an idle write
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !(base_we && wave_mode == 2'b00)) |=> $stable(code_out));

  // R9: idle write goes straight to the output
  a_r9_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && wave_mode == 2'b00) |=> (code_out == $past(base_wdata)));

  // R10: the all-zero noise word steps to one
  a_r10_escape_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_step && lfsr_q == '0) |=> (lfsr_q == 12'h001));

endmodule

bind dac_wave_synth dws_chk #(.W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig       (trig),
  .wave_mode  (wave_mode),
  .base_we    (base_we),
  .base_wdata (base_wdata),
  .code_out   (code_out),
  .base_val   (base_val),
  .lfsr_q     (lfsr_q),
  .tri_cnt    (tri_cnt),
  .tri_step   (tri_step),
  .noise_step (noise_step),
  .gen_clear  (gen_clear)
);

// File: tb/tb_dac_wave_synth.sv
module tb_dac_wave_synth;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  amp;
    logic [11:0] base;
    logic [15:0] steps;
    logic [11:0] expect_code;
  } vec_t;

  // each entry: clear, write base in idle, select mode/amp, fire steps
  localparam vec_t VECS [NVEC] = '{
    '{2'b10, 4'd0,  12'h100, 16'd3,  12'h101},  // R6 peak 1
    '{2'b10, 4'd1,  12'h010, 16'd5,  12'h011},  // R6 peak 3, descending
    '{2'b11, 4'd3,  12'h000, 16'd15, 12'h00F},  // R7 mode 11 reaches peak
    '{2'b10, 4'd3,  12'hFF5, 16'd16, 12'hFFF},  // R3 saturation on triangle
    '{2'b11, 4'd15, 12'h200, 16'd5,  12'h205},  // R5 clamped code on triangle
    '{2'b10, 4'd12, 12'hFFE, 16'd2,  12'hFFF},  // R3 saturation by two
    '{2'b01, 4'd0,  12'h000, 16'd1,  12'h001},  // R4 first step, one bit kept
    '{2'b01, 4'd11, 12'h100, 16'd1,  12'h655},  // R4 full word
    '{2'b01, 4'd3,  12'hFF0, 16'd2,  12'hFFB},  // R5 four bits kept
    '{2'b01, 4'd13, 12'h000, 16'd1,  12'h555}   // R5 code 13 acts as 11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [11:0] base_wdata = '0;
  logic [1:0]  wave_mode = 2'b00;
  logic [3:0]  amp_sel = '0;
  logic        trig = 1'b0;
  logic [11:0] code_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_wave_synth dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_we    (base_we),
    .base_wdata (base_wdata),
    .wave_mode  (wave_mode),
    .amp_sel    (amp_sel),
    .trig       (trig),
    .code_out   (code_out)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%03h expected 0x%03h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic idle_write(input logic [11:0] v);
    @(negedge clk);
    wave_mode = 2'b00;
    base_we = 1'b1;
    base_wdata = v;
    @(negedge clk) base_we = 1'b0;
  endtask

  // bench model of the shift register, bit by bit
  function automatic logic [11:0] model_next(input logic [11:0] r);
    logic f;
    f = r[11] ^ r[5] ^ r[3] ^ r[0];
    if ((r & 12'h7FF) == 12'h000) f = !f;
    return ((r << 1) & 12'hFFF) | {11'd0, f};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got 0x000 expected 0x001");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] m;
    logic [11:0] hold;
    int mism;
    bit saw_zero;

    repeat (3) @(negedge clk);
    check("R1 output during reset", code_out, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 output after reset", code_out, 12'h000);
    // R1 base is zero: a triangle step from reset yields exactly 1
    wave_mode = 2'b10; amp_sel = 4'd2;
    pulse();
    check("R1 base zero, triangle starts at 0", code_out, 12'h001);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      idle_write(VECS[i].base);
      wave_mode = VECS[i].mode;
      amp_sel = VECS[i].amp;
      for (int k = 0; k < int'(VECS[i].steps); k++) pulse();
      check($sformatf("vector %0d (R3 R4 R5 R6 R7)", i), code_out, VECS[i].expect_code);
    end

    // R9: idle write shows up directly
    idle_write(12'h3C5);
    check("R9 idle write loads output", code_out, 12'h3C5);

    // R2: triggers in idle leave the generators parked
    wave_mode = 2'b00;
    repeat (5) pulse();
    check("R2 idle trigger gives base", code_out, 12'h3C5);
    idle_write(12'h000);
    amp_sel = 4'd11;
    wave_mode = 2'b01;
    pulse();
    check("R2 noise restarts from seed", code_out, 12'h555);

    // R9: busy write is deferred until the trigger
    wave_mode = 2'b10; amp_sel = 4'd4;
    idle_write(12'h000);
    wave_mode = 2'b10;
    @(negedge clk) base_we = 1'b1; base_wdata = 12'h400;
    @(negedge clk) base_we = 1'b0;
    check("R9 busy write not on output", code_out, 12'h000);
    pulse();
    check("R9 busy write used at trigger", code_out, 12'h401);

    // R8: output holds while idle of triggers, even across mode/amp change
    hold = code_out;
    amp_sel = 4'd9;
    repeat (4) @(negedge clk);
    wave_mode = 2'b01;
    repeat (3) @(negedge clk);
    check("R8 output holds without trigger", code_out, hold);

    // R10: full noise period through the zero word
    idle_write(12'h000);
    wave_mode = 2'b01;
    amp_sel = 4'd15;
    m = 12'hAAA;
    mism = 0;
    saw_zero = 1'b0;
    for (int s = 0; s < 4096; s++) begin
      pulse();
      m = model_next(m);
      if (code_out !== m) mism++;
      if (code_out == 12'h000) saw_zero = 1'b1;
    end
    check("R10 every step matches model (mismatch count)", mism[11:0], 12'h000);
    check("R10 zero word visited", {11'd0, saw_zero}, 12'h001);
    check("R10 period returns to seed", code_out, 12'hAAA);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule